// File: doc/BRIEF.md
# Dual-Mode Per-Processor Timer

This block is a timer owned by one processor. A mode input, driven from a system-wide mask, picks how it behaves. In interval mode it counts time periods up to a programmable limit. When it reaches the limit it wraps to zero, sets a reached flag and raises an interrupt. A limit of zero makes it run freely over its whole 31-bit range. In user mode the same count register becomes a 63-bit up-counter. Software can preload it one 32-bit half at a time, and can start or stop it. When it overflows it sets the reached flag and does not interrupt.

Registers are selected by a word index. What each index means depends on the mode. A change of the mode input restarts the counter from zero. The count always advances in units of bit 9, so its bottom nine bits are always zero. One period lasts `TICK_DIV` clock cycles.

Top module: `cpu_timer_dual`

## Requirements
- R1: After reset the block is in interval mode, the run flag is 1, the limit is 0 (read at index 0 returns 0), the reached flag is 0 and `irq_o` is low.
- R2: In interval mode, index 0 holds the limit in bits 30:9, and all other bits of a write are dropped. A write there clears the count and lowers `irq_o`. A read there returns the limit and clears both the reached flag and `irq_o`.
- R3: In interval mode the count advances by one period (0x200) per tick. The step that would reach the limit instead returns the count to 0, sets the reached flag (bit 31 of index 1) and raises `irq_o`. A limit of zero counts over the full 0x7FFFFE00 range.
- R4: In interval mode, writing index 2 sets the limit and leaves the count alone. Writing index 1 has no effect. A read of index 1 returns {reached, count[30:9], nine zeros}.
- R5: In user mode, index 0 reads as the reached flag in bit 31 above count bits 62:32. Index 1 reads as count bits 31:0, and its bits 8:0 are always zero.
- R6: In user mode, a write to index 0 loads count bits 62:32 from data bits 30:0. A write to index 1 loads count bits 31:9 from data bits 31:9. Either write clears the reached flag. The load takes effect at the next clock edge, and counting then continues from the combined value, with carry between the halves.
- R7: In user mode, writing index 3 starts the counter when data bit 0 is 1 and stops it when that bit is 0. A read of index 3 returns the run flag in bit 0. A stopped counter holds its value and resumes from it when started again.
- R8: In user mode, a step from 0x7FFFFFFFFFFFFC00 wraps the count to 0 and sets the reached flag. `irq_o` stays low throughout user mode.
- R9: At the clock edge where `user_mode_i` differs from the active mode, the count becomes 0, the reached flag and `irq_o` clear, and the run flag is set. Entering user mode also sets the limit to 0x7FFFFE00.
- R10: One tick occurs every `TICK_DIV` clock cycles. In any window of `TICK_DIV` consecutive edges, a counter that is running and not being loaded advances by exactly one period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| user_mode_i | input | 1 | 1 selects user (wide counter) mode, 0 interval mode |
| wr_en_i | input | 1 | Register write strobe |
| wr_idx_i | input | IDX_W | Word index of the write |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Register read strobe (carries the read side effects) |
| rd_idx_i | input | IDX_W | Word index of the read |
| rd_data_o | output | 32 | Read data, combinational from the current state |
| irq_o | output | 1 | Interrupt, interval mode only |

## Verification
Read data is combinational, so a value read at a negative edge reflects every edge before it. A write or a read side effect becomes visible after exactly one rising edge. A tick falls on exactly one edge out of every `TICK_DIV`, so the bench never predicts the tick phase. Instead it counts edges from a write that resets or loads the count: after k·`TICK_DIV` edges exactly k periods have passed. Checks of the interrupt, the carry and the wrap fall at those boundaries. Rate checks take the difference of two reads spaced k·`TICK_DIV` edges apart, and a user-mode stop freezes the count so both halves can be read without ambiguity.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   // Register word indices; index 0 and 1 swap meaning with the mode.
   localparam int unsigned IDX_LIMIT = 0;
   localparam int unsigned IDX_COUNT = 1;
   localparam int unsigned IDX_NORST = 2;
   localparam int unsigned IDX_RUN   = 3;
endpackage

// File: rtl/tmr_tick.sv
module tmr_tick #(
   parameter int unsigned DIV = 5
) (
   input  logic clk_i,
   input  logic rst_ni,
   output logic tick_o
);
   generate
      if (DIV < 1) begin : g_bad_div
         $error("tmr_tick: DIV must be at least 1");
      end
      if (DIV == 1) begin : g_every
         assign tick_o = 1'b1;
      end else begin : g_div
         localparam int unsigned PW = $clog2(DIV);
         logic [PW-1:0] pc_q;
         always_ff @(posedge clk_i) begin
            if (!rst_ni)                     pc_q <= '0;
            else if (pc_q == PW'(DIV - 1))   pc_q <= '0;
            else                             pc_q <= pc_q + PW'(1);
         end
         assign tick_o = (pc_q == PW'(DIV - 1));

         AST_TICK_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
            tick_o |=> !tick_o); // R10
      end
   endgenerate
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
   parameter int unsigned PER_W = 54,
   parameter int unsigned LO_W  = 23
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              run_i,
   input  logic              clr_i,
   input  logic              ld_hi_i,
   input  logic              ld_lo_i,
   input  logic [PER_W-LO_W-1:0] hi_i,
   input  logic [LO_W-1:0]   lo_i,
   input  logic [PER_W-1:0]  wrap_at_i,
   output logic [PER_W-1:0]  cnt_o,
   output logic              wrap_o
);
   logic [PER_W-1:0] cnt_q;
   logic [PER_W-1:0] nxt;
   logic             step;

   assign step   = tick_i && run_i && !clr_i && !ld_hi_i && !ld_lo_i;
   assign nxt    = cnt_q + PER_W'(1);
   assign wrap_o = step && (nxt >= wrap_at_i);
   assign cnt_o  = cnt_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni)       cnt_q <= '0;
      else if (clr_i)    cnt_q <= '0;
      else if (ld_hi_i)  cnt_q <= {hi_i, cnt_q[LO_W-1:0]};
      else if (ld_lo_i)  cnt_q <= {cnt_q[PER_W-1:LO_W], lo_i};
      else if (wrap_o)   cnt_q <= '0;
      else if (step)     cnt_q <= nxt;
   end

   AST_STOP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run_i && !clr_i && !ld_hi_i && !ld_lo_i) |=> $stable(cnt_q)); // R7
   AST_WRAP_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wrap_o |=> (cnt_q == '0)); // R8
endmodule

// File: rtl/cpu_timer_dual.sv
module cpu_timer_dual #(
   parameter int unsigned WIDE_W   = 63,
   parameter int unsigned NARROW_W = 31,
   parameter int unsigned FRAC_W   = 9,
   parameter int unsigned TICK_DIV = 5,
   parameter int unsigned IDX_W    = 3
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             user_mode_i,
   input  logic             wr_en_i,
   input  logic [IDX_W-1:0] wr_idx_i,
   input  logic [31:0]      wr_data_i,
   input  logic             rd_en_i,
   input  logic [IDX_W-1:0] rd_idx_i,
   output logic [31:0]      rd_data_o,
   output logic             irq_o
);
   import tmr_pkg::*;

   localparam int unsigned PER_W  = WIDE_W - FRAC_W;
   localparam int unsigned NPER_W = NARROW_W - FRAC_W;
   localparam int unsigned LO_W   = 32 - FRAC_W;
   localparam int unsigned HI_W   = PER_W - LO_W;

   generate
      if (WIDE_W <= 32 || WIDE_W > 63) begin : g_bad_wide
         $error("cpu_timer_dual: WIDE_W must lie in 33..63");
      end
      if (NARROW_W > 31 || NARROW_W <= FRAC_W) begin : g_bad_narrow
         $error("cpu_timer_dual: NARROW_W must exceed FRAC_W and be at most 31");
      end
      if (FRAC_W < 2) begin : g_bad_frac
         $error("cpu_timer_dual: FRAC_W must be at least 2");
      end
   endgenerate

   logic              user_q, mode_chg;
   logic              run_q, reached_q, irq_q;
   logic [NPER_W-1:0] lim_q, lim_eff;
   logic              wr_lim, wr_cnt, wr_norst, wr_run, rd_clr;
   logic              ld_hi, ld_lo, clr, run_en, tick, wrap;
   logic [PER_W-1:0]  wrap_at, cnt;
   logic              unused_wd;

   assign unused_wd = ^wr_data_i[FRAC_W-1:1];

   assign mode_chg = user_mode_i ^ user_q;
   assign wr_lim   = wr_en_i && !mode_chg && (wr_idx_i == IDX_W'(IDX_LIMIT));
   assign wr_cnt   = wr_en_i && !mode_chg && (wr_idx_i == IDX_W'(IDX_COUNT));
   assign wr_norst = wr_en_i && !mode_chg && (wr_idx_i == IDX_W'(IDX_NORST));
   assign wr_run   = wr_en_i && !mode_chg && (wr_idx_i == IDX_W'(IDX_RUN));
   assign rd_clr   = rd_en_i && !mode_chg && !user_q && (rd_idx_i == IDX_W'(IDX_LIMIT));

   assign ld_hi  = user_q && wr_lim;
   assign ld_lo  = user_q && wr_cnt;
   assign clr    = mode_chg || (!user_q && wr_lim);
   assign run_en = user_q ? run_q : 1'b1;

   assign lim_eff = (lim_q == '0) ? '1 : lim_q;
   assign wrap_at = user_q ? '1 : {{(PER_W-NPER_W){1'b0}}, lim_eff};

   tmr_tick #(.DIV(TICK_DIV)) u_tick (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_o (tick)
   );

   tmr_count #(.PER_W(PER_W), .LO_W(LO_W)) u_count (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick),
      .run_i     (run_en),
      .clr_i     (clr),
      .ld_hi_i   (ld_hi),
      .ld_lo_i   (ld_lo),
      .hi_i      (wr_data_i[HI_W-1:0]),
      .lo_i      (wr_data_i[31:FRAC_W]),
      .wrap_at_i (wrap_at),
      .cnt_o     (cnt),
      .wrap_o    (wrap)
   );

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         user_q    <= 1'b0;
         run_q     <= 1'b1;
         lim_q     <= '0;
         reached_q <= 1'b0;
         irq_q     <= 1'b0;
      end else begin
         user_q <= user_mode_i;
         if (mode_chg) begin
            run_q     <= 1'b1;
            reached_q <= 1'b0;
            irq_q     <= 1'b0;
            if (user_mode_i) lim_q <= '1;
         end else begin
            if (user_q && wr_run) run_q <= wr_data_i[0];
            if (!user_q && (wr_lim || wr_norst)) lim_q <= wr_data_i[NARROW_W-1:FRAC_W];
            if (wrap)                        reached_q <= 1'b1;
            else if (ld_hi || ld_lo || rd_clr) reached_q <= 1'b0;
            if (wrap && !user_q)               irq_q <= 1'b1;
            else if (rd_clr || (!user_q && wr_lim)) irq_q <= 1'b0;
         end
      end
   end

   assign irq_o = irq_q;

   always_comb begin
      rd_data_o = '0;
      if (rd_idx_i == IDX_W'(IDX_LIMIT)) begin
         if (user_q) begin
            rd_data_o[HI_W-1:0] = cnt[PER_W-1:LO_W];
            rd_data_o[31]       = reached_q;
         end else begin
            rd_data_o[NARROW_W-1:FRAC_W] = lim_q;
         end
      end else if (rd_idx_i == IDX_W'(IDX_COUNT)) begin
         if (user_q) begin
            rd_data_o[31:FRAC_W] = cnt[LO_W-1:0];
         end else begin
            rd_data_o[NARROW_W-1:FRAC_W] = cnt[NPER_W-1:0];
            rd_data_o[31]                = reached_q;
         end
      end else if (rd_idx_i == IDX_W'(IDX_RUN)) begin
         rd_data_o[0] = run_q;
      end
   end

   AST_USER_NO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      user_q |-> !irq_o); // R8
   AST_MODE_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mode_chg |=> (cnt == '0 && !reached_q && !irq_o && run_q)); // R9
   AST_LOAD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ld_hi || ld_lo) |=> !reached_q); // R6
   AST_READ_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_clr && !wrap) |=> (!irq_o && !reached_q)); // R2
endmodule

// File: tb/sim_cpu_timer_dual.sv
`timescale 1ns/1ps
module sim_cpu_timer_dual;
   localparam int unsigned DIV   = 5;
   localparam int unsigned IDX_W = 3;

   logic             clk = 1'b0;
   logic             rst_ni = 1'b0;
   logic             user_mode_i = 1'b0;
   logic             wr_en_i = 1'b0;
   logic [IDX_W-1:0] wr_idx_i = '0;
   logic [31:0]      wr_data_i = '0;
   logic             rd_en_i = 1'b0;
   logic [IDX_W-1:0] rd_idx_i = '0;
   logic [31:0]      rd_data_o;
   logic             irq_o;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   cpu_timer_dual #(.TICK_DIV(DIV), .IDX_W(IDX_W)) u0 (
      .clk_i(clk), .rst_ni(rst_ni), .user_mode_i(user_mode_i),
      .wr_en_i(wr_en_i), .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i),
      .rd_en_i(rd_en_i), .rd_idx_i(rd_idx_i), .rd_data_o(rd_data_o),
      .irq_o(irq_o)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   // All tasks start and end at a negative edge.
   task automatic wr(input int idx, input logic [31:0] d);
      wr_en_i = 1'b1; wr_idx_i = IDX_W'(idx); wr_data_i = d;
      @(negedge clk);
      wr_en_i = 1'b0;
   endtask

   task automatic rd(input int idx, output logic [31:0] d);
      rd_en_i = 1'b1; rd_idx_i = IDX_W'(idx);
      #1 d = rd_data_o;
      @(negedge clk);
      rd_en_i = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=%08h expected=%08h", 32'd0, 32'd1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] v, a, b;
      idle(3);
      rst_ni = 1'b1;
      // R1 reset state
      check("R1 irq", {31'd0, irq_o}, 32'd0);
      rd(0, v); check("R1 limit", v, 32'd0);
      rd(3, v); check("R1 run", v, 32'd1);
      rd(1, v); check("R1 reached", {31'd0, v[31]}, 32'd0);

      // R3 / R2: limit sweep of 1..4 periods
      for (int n = 1; n <= 4; n++) begin
         wr(0, 32'(n) << 9);
         idle((n - 1) * DIV);
         check("R3 irq before limit", {31'd0, irq_o}, 32'd0);
         idle(DIV);
         check("R3 irq at limit", {31'd0, irq_o}, 32'd1);
         if (n >= 2) begin
            rd(1, v); check("R3 reached bit", {31'd0, v[31]}, 32'd1);
            rd(0, v); check("R2 limit readback", v, 32'(n) << 9);
            check("R2 read clears irq", {31'd0, irq_o}, 32'd0);
            rd(1, v); check("R2 read clears reached", {31'd0, v[31]}, 32'd0);
         end
      end
      wr(0, 32'hFFFF_FFFF);
      rd(0, v); check("R2 limit mask", v, 32'h7FFF_FE00);
      check("R2 write lowers irq", {31'd0, irq_o}, 32'd0);

      // R4: limit write without reset, ignored count write; R10 rate
      wr(0, 32'd0);
      idle(3 * DIV - 2);
      wr(2, 32'h0010_0000);
      wr(1, 32'hFFFF_FFFF);
      rd(1, v); check("R4 R10 count kept three periods", v, 32'h0000_0600);
      rd(0, v); check("R4 norst limit", v, 32'h0010_0000);

      // R9 enter user mode
      user_mode_i = 1'b1;
      idle(1);
      check("R9 irq low", {31'd0, irq_o}, 32'd0);
      rd(1, v); check("R9 count restarted", v, 32'd0);
      rd(3, v); check("R9 running", v, 32'd1);
      rd(0, v); check("R9 high and reached", v, 32'd0);

      // R6 / R7 load halves while stopped
      wr(3, 32'd0);
      wr(1, 32'h0001_2345);
      wr(0, 32'd5);
      rd(1, v); check("R6 R5 low load", v, 32'h0001_2200);
      rd(0, v); check("R6 high load", v, 32'd5);
      idle(3 * DIV);
      rd(1, v); check("R7 stopped holds low", v, 32'h0001_2200);
      rd(0, v); check("R7 stopped holds high", v, 32'd5);
      rd(3, v); check("R7 run readback", v, 32'd0);

      // R10 rate sweep in user mode
      wr(3, 32'd1);
      for (int k = 1; k <= 4; k++) begin
         rd(1, a);
         idle(k * DIV - 1);
         rd(1, b);
         check("R10 R7 periods per window", b - a, 32'(k) << 9);
         check("R5 low bits zero", {23'd0, b[8:0]}, 32'd0);
      end

      // R6 carry across halves
      wr(1, 32'hFFFF_FE00);
      wr(0, 32'd3);
      idle(DIV - 1);
      wr(3, 32'd0);
      rd(0, v); check("R6 carry high", v, 32'd4);
      rd(1, v); check("R6 carry low", v, 32'd0);

      // R8 wrap at maximum
      wr(3, 32'd1);
      wr(1, 32'hFFFF_FC00);
      wr(0, 32'h7FFF_FFFF);
      idle(DIV - 1);
      wr(3, 32'd0);
      rd(0, v); check("R8 reached, high zero", v, 32'h8000_0000);
      rd(1, v); check("R8 low zero", v, 32'd0);
      check("R8 no irq", {31'd0, irq_o}, 32'd0);
      wr(1, 32'h0000_0200);
      rd(0, v); check("R6 write clears reached", v, 32'd0);
      wr(0, 32'hFFFF_FFFF);
      rd(0, v); check("R6 high mask", v, 32'h7FFF_FFFF);

      // R9 back to interval mode
      user_mode_i = 1'b0;
      idle(1);
      rd(1, v); check("R9 count cleared on leave", v, 32'd0);
      rd(0, v); check("R9 limit all ones", v, 32'h7FFF_FE00);
      rd(3, v); check("R9 run set", v, 32'd1);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule